// File: doc/BRIEF.md
# Memory bus cycle engine

This block is the master side of a processor-style asynchronous memory bus. It has a 19-bit address, an 8-bit data path split into an output, an output enable and an input, and three active-low strobes: a memory request that frames an access, a read strobe and a write strobe. It takes one command at a time and turns it into strobe sequences whose timing is set by parameters counted in system clock cycles.

There are five commands. A single read and a single write each move one byte. A fill writes one constant byte over a range of addresses. A stream read returns bytes on a valid strobe. A stream write takes bytes through a valid/ready handshake. In every multi-byte command the memory request falls once before the first byte and rises once after the last. In between, the address steps by one and the matching strobe pulses once for each byte. Bus ownership is assumed to be granted already. There is no wait-state input.

Top module: `membus_engine`

## Requirements
- R1: While reset is held and in the cycle after it, memory request, read and write are all high, the data output enable is low, busy is low and cmd_ready is high.
- R2: A single read (cmd_op 0, cmd_len ignored) does the following. It presents the address and drives memory request low. After SETUP_CYC cycles it holds read low for RD_LOW_CYC cycles and samples bus_din on the last of them. It raises read with rd_valid high for exactly that one cycle, and raises memory request on the next cycle.
- R3: A single write (cmd_op 1, cmd_len ignored) drives cmd_data with the output enable high from the cycle memory request falls. It holds write low for WR_LOW_CYC cycles and raises memory request on the cycle after write rises.
- R4: Read and write are never low together, and neither is low while memory request is high.
- R5: Fill (cmd_op 2), stream read (cmd_op 3) and stream write (cmd_op 4) with length N lower memory request exactly once and give exactly N strobe pulses. The addresses are cmd_addr+k modulo 2^19 for k = 0..N-1. Each address is held for at least SETUP_CYC cycles before its strobe falls.
- R6: During a fill, the data output keeps the value of cmd_data for as long as memory request is low.
- R7: A stream write consumes one byte per cycle with wr_valid and wr_ready both high. It holds off the write strobe while no byte is offered, and writes the bytes in order.
- R8: The data output enable is high only while memory request is low during a write, fill or stream write. It is never high during a read or stream read.
- R9: A fill or stream command with cmd_len 0 is accepted and causes no bus activity: memory request stays high and busy stays low.
- R10: Busy is high from the cycle after a command that moves bytes is accepted until the cycle memory request rises. cmd_ready is low while busy, and commands offered then are ignored.
- R11: The address is stable in every cycle a strobe is low and in the cycle it rises.
- R12: Op codes 5 to 7 are accepted and cause no bus activity and no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken this cycle if offered |
| cmd_op | input | 3 | Command code (0 read, 1 write, 2 fill, 3 stream read, 4 stream write) |
| cmd_addr | input | 19 | Start address |
| cmd_len | input | 8 | Byte count for fill and stream commands |
| cmd_data | input | 8 | Byte for single write and fill |
| wr_valid | input | 1 | Stream write byte offered |
| wr_ready | output | 1 | Stream write byte taken |
| wr_data | input | 8 | Stream write byte |
| rd_valid | output | 1 | Read byte valid, one cycle per byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Access in progress |
| bus_addr | output | 19 | Memory address |
| bus_mreq_n | output | 1 | Memory request, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 8 | Data driven to memory |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 8 | Data returned by memory |

## Verification
The hardest condition to reach from the ports is a stream write whose write strobe must wait for a late byte while memory request stays low and the address does not move. A feeder in the bench withholds wr_valid on a fixed cycle pattern, so some bytes arrive after the engine has already stepped its address. The other hard case is a command offered while the engine is busy. The bench holds a write command on the command port through a whole stream read and then checks that the behavioural memory is unchanged. The address wrap at the top of the 19-bit space is reached by starting a stream read two bytes below it.

// File: rtl/membus_pkg.sv
// Shared types of the memory bus cycle engine.
package membus_pkg;

    typedef enum logic [2:0] {
        OP_RD   = 3'd0,
        OP_WR   = 3'd1,
        OP_FILL = 3'd2,
        OP_SRD  = 3'd3,
        OP_SWR  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } state_e;

endpackage

// File: rtl/membus_delay.sv
// Down counter that times the address setup and strobe widths.
// Assumes the load value is at most 2^CNT_W-1. It sits at zero when not loaded.
module membus_delay #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new interval, or count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/membus_addr_seq.sv
// Address register and remaining-byte counter for one command.
// Assumes load and step are never high together. Steps wrap modulo 2^ADDR_W.
module membus_addr_seq #(
    parameter int ADDR_W = 19,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    logic [LEN_W-1:0] rem_q;

    // Take the start address and count, then advance one byte per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            rem_q <= '0;
        end else if (load) begin
            addr  <= load_addr;
            rem_q <= load_len;
        end else if (step) begin
            addr  <= addr + ADDR_W'(1);
            rem_q <= rem_q - LEN_W'(1);
        end
    end

    assign last = (rem_q == LEN_W'(1));

endmodule

// File: rtl/membus_engine.sv
// Memory bus cycle engine: runs single, fill and stream byte accesses on an
// asynchronous bus with active-low request, read and write strobes.
// Assumes the bus is already granted and that memory needs no wait states.
// Timing parameters are in clock cycles and must each be at least 1.
module membus_engine #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 8,
    parameter int SETUP_CYC  = 1,
    parameter int RD_LOW_CYC = 3,
    parameter int WR_LOW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_mreq_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din
);
    import membus_pkg::*;

    localparam int MAX_A   = (SETUP_CYC > RD_LOW_CYC) ? SETUP_CYC : RD_LOW_CYC;
    localparam int MAX_CYC = (MAX_A > WR_LOW_CYC) ? MAX_A : WR_LOW_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    state_e            state_q;
    op_e               op_q;
    logic              accept, op_known, op_single, op_read, start;
    logic [LEN_W-1:0]  len_eff;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic              seq_step, seq_last;

    // Decode the offered command.
    always_comb begin
        accept    = cmd_valid && cmd_ready;
        op_known  = (cmd_op <= 3'd4);
        op_single = (cmd_op == OP_RD) || (cmd_op == OP_WR);
        op_read   = (cmd_op == OP_RD) || (cmd_op == OP_SRD);
        len_eff   = op_single ? LEN_W'(1) : cmd_len;
        start     = accept && op_known && (len_eff != '0);
    end

    // Choose when the delay counter restarts, and with which interval.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(SETUP_CYC - 1);
        seq_step = 1'b0;
        unique case (state_q)
            ST_IDLE:   tmr_load = start && (cmd_op != OP_SWR);
            ST_FETCH:  tmr_load = wr_valid;
            ST_SETUP: begin
                tmr_load = tmr_expired;
                tmr_val  = (op_q == OP_RD || op_q == OP_SRD) ?
                           CNT_W'(RD_LOW_CYC - 1) : CNT_W'(WR_LOW_CYC - 1);
            end
            ST_HOLD: begin
                seq_step = !seq_last;
                tmr_load = !seq_last && (op_q != OP_SWR);
            end
            default: ;
        endcase
    end

    membus_delay #(.CNT_W(CNT_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    membus_addr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_addr (cmd_addr),
        .load_len  (len_eff),
        .step      (seq_step),
        .addr      (bus_addr),
        .last      (seq_last)
    );

    // Sequence request, strobes, data enable and read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_RD;
            bus_mreq_n <= 1'b1;
            bus_rd_n   <= 1'b1;
            bus_wr_n   <= 1'b1;
            bus_doe    <= 1'b0;
            bus_dout   <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q       <= op_e'(cmd_op);
                    bus_mreq_n <= 1'b0;
                    bus_doe    <= !op_read;
                    bus_dout   <= cmd_data;
                    state_q    <= (cmd_op == OP_SWR) ? ST_FETCH : ST_SETUP;
                end
                ST_FETCH: if (wr_valid) begin
                    bus_dout <= wr_data;
                    state_q  <= ST_SETUP;
                end
                ST_SETUP: if (tmr_expired) begin
                    if (op_q == OP_RD || op_q == OP_SRD)
                        bus_rd_n <= 1'b0;
                    else
                        bus_wr_n <= 1'b0;
                    state_q <= ST_STROBE;
                end
                ST_STROBE: if (tmr_expired) begin
                    bus_rd_n <= 1'b1;
                    bus_wr_n <= 1'b1;
                    if (!bus_rd_n) begin
                        rd_valid <= 1'b1;
                        rd_data  <= bus_din;
                    end
                    state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (seq_last) begin
                        bus_mreq_n <= 1'b1;
                        bus_doe    <= 1'b0;
                        state_q    <= ST_IDLE;
                    end else begin
                        state_q <= (op_q == OP_SWR) ? ST_FETCH : ST_SETUP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign cmd_ready = !busy;
    assign wr_ready  = (state_q == ST_FETCH);

    // Strobes are exclusive and stay inside the request frame.
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));
    p_strobe_in_mreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !bus_mreq_n);

    // The address cannot move under a low strobe or at its rising edge.
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |=> $stable(bus_addr));

    // Inside one request frame the address only advances by one.
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mreq_n && !$past(bus_mreq_n) && (bus_addr != $past(bus_addr)))
        |-> (bus_addr == $past(bus_addr) + ADDR_W'(1)));

    // Fill data never changes inside the frame.
    p_fill_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_FILL && !bus_mreq_n && !$past(bus_mreq_n)) |-> $stable(bus_dout));

    // The data driver is on only inside a frame of a write-type command.
    p_oe_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!bus_mreq_n && bus_rd_n && op_q != OP_RD && op_q != OP_SRD));

    // A request frame is always covered by busy.
    p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_mreq_n |-> busy);

    // Read data is returned exactly when the read strobe rises.
    p_rdvalid_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(bus_rd_n));

    // Request rises only after both strobes are already high.
    p_mreq_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_mreq_n) |-> ($past(bus_rd_n) && $past(bus_wr_n)));

    // Empty range commands leave the bus idle.
    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cmd_op == OP_FILL || cmd_op == OP_SRD || cmd_op == OP_SWR)
         && cmd_len == '0) |=> (bus_mreq_n && !busy));

    // Unknown codes leave the bus idle.
    p_bad_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op > 3'd4) |=> (bus_mreq_n && !busy));

endmodule

// File: tb/membus_engine_tb.sv
`timescale 1ns/1ps
module membus_engine_tb;

    localparam int AW = 19, DW = 8, LW = 8, SU = 2, RDL = 3, WRL = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [DW-1:0] cmd_data = '0;
    logic wr_valid = 1'b0, wr_ready;
    logic [DW-1:0] wr_data = '0;
    logic rd_valid, busy;
    logic [DW-1:0] rd_data, bus_dout, bus_din;
    logic [AW-1:0] bus_addr;
    logic bus_mreq_n, bus_rd_n, bus_wr_n, bus_doe;

    always #2 clk = ~clk;

    membus_engine #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .SETUP_CYC(SU),
                    .RD_LOW_CYC(RDL), .WR_LOW_CYC(WRL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .bus_addr(bus_addr),
        .bus_mreq_n(bus_mreq_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din));

    // Behavioural memory, 64 bytes decoded from the low address bits.
    logic [7:0] mem [64];
    assign bus_din = !bus_rd_n ? mem[bus_addr[5:0]] : 8'h00;

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor state.
    int pulses_rd, pulses_wr, pulse_n, mreq_falls, viol, rd_cnt, oe_cycles;
    int lo_cnt, since_chg, since_rise;
    bit busy_seen, first_busy;
    logic [2:0] cur_op;
    logic [AW-1:0] paddr [32];
    logic [7:0] pdata [32];
    logic [7:0] rbuf [32];
    logic p_mreq_n = 1'b1, p_rd_n = 1'b1, p_wr_n = 1'b1;
    logic [AW-1:0] p_addr = '0;
    logic [7:0] p_dout = '0;

    task automatic clear_mon();
        pulses_rd = 0; pulses_wr = 0; pulse_n = 0; mreq_falls = 0; viol = 0;
        rd_cnt = 0; oe_cycles = 0; busy_seen = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic lo, p_lo;
            lo   = !bus_rd_n || !bus_wr_n;
            p_lo = !p_rd_n || !p_wr_n;
            if (!bus_rd_n && !bus_wr_n) viol++;
            if (lo && bus_mreq_n) viol++;
            if (bus_doe && (bus_mreq_n || !bus_rd_n)) viol++;
            if (!bus_wr_n && !bus_doe) viol++;
            if (bus_doe) oe_cycles++;
            if (cur_op == 3'd2 && !bus_mreq_n && !p_mreq_n && bus_dout != p_dout) viol++;
            if (!bus_mreq_n && !busy) viol++;
            if (busy) busy_seen = 1;
            if (p_mreq_n && !bus_mreq_n) mreq_falls++;
            if (!p_mreq_n && bus_mreq_n && since_rise != 0) viol++;
            if (lo && !p_lo) begin
                if (since_chg < SU) viol++;
                lo_cnt = 1;
            end else if (lo) begin
                lo_cnt++;
                if (bus_addr != p_addr) viol++;
            end
            if (!lo && p_lo) begin
                if (lo_cnt != (!p_rd_n ? RDL : WRL)) viol++;
                if (bus_addr != p_addr) viol++;
                if (pulse_n < 32) begin
                    paddr[pulse_n] = p_addr;
                    pdata[pulse_n] = p_dout;
                end
                if (!p_wr_n) begin
                    mem[p_addr[5:0]] = p_dout;
                    pulses_wr++;
                end else pulses_rd++;
                pulse_n++;
                since_rise = 0;
            end else since_rise++;
            if (rd_valid) begin
                if (!(!p_rd_n && bus_rd_n)) viol++;
                if (rd_cnt < 32) rbuf[rd_cnt] = rd_data;
                rd_cnt++;
            end
            if (bus_mreq_n) since_chg = 0;
            else if (p_mreq_n || bus_addr != p_addr) since_chg = 1;
            else since_chg++;
        end
        p_mreq_n = bus_mreq_n; p_rd_n = bus_rd_n; p_wr_n = bus_wr_n;
        p_addr = bus_addr; p_dout = bus_dout;
    end

    // Stream write feeder, withholding a byte on every third cycle.
    logic [7:0] wsrc [32];
    int wptr = 0, wlen = 0, fcyc = 0;
    bit feed_en = 0, take_pending = 0;
    always @(negedge clk) begin
        fcyc++;
        if (take_pending) begin
            wptr++;
            take_pending = 0;
        end
        if (feed_en && wptr < wlen && (fcyc % 3) != 1) begin
            wr_valid = 1'b1;
            wr_data  = wsrc[wptr];
        end else wr_valid = 1'b0;
        if (wr_valid && wr_ready) take_pending = 1;
    end

    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                           input int len, input logic [7:0] d);
        clear_mon();
        cur_op = op;
        if (op == 3'd4) begin
            wptr = 0; wlen = len; take_pending = 0; feed_en = 1;
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_len = len[LW-1:0]; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        first_busy = busy;
        while (busy) @(negedge clk);
        @(negedge clk);
        feed_en = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog: actual busy expected idle");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        clear_mon();
        cur_op = 3'd0;
        repeat (3) @(negedge clk);
        check(bus_mreq_n && bus_rd_n && bus_wr_n && !bus_doe && !busy && cmd_ready,
              "R1", "strobes/busy in reset", {bus_mreq_n, bus_rd_n, bus_wr_n, bus_doe, busy}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_mreq_n && bus_rd_n && bus_wr_n && !bus_doe && !busy && cmd_ready,
              "R1", "idle after reset", {bus_mreq_n, bus_rd_n, bus_wr_n, bus_doe, busy}, 5'b11100);

        // Single write.
        run_cmd(3'd1, 19'h12345, 0, 8'hA5);
        check(pulses_wr == 1 && pulses_rd == 0, "R3", "write pulses", pulses_wr, 1);
        check(paddr[0] == 19'h12345, "R3", "write address", paddr[0], 19'h12345);
        check(mem[6'h05] == 8'hA5, "R3", "memory after write", mem[6'h05], 8'hA5);
        check(viol == 0, "R3", "write timing violations", viol, 0);
        check(first_busy, "R10", "busy after accept", first_busy, 1);
        check(oe_cycles > 0, "R8", "driver on during write", oe_cycles, 1);

        // Single reads.
        run_cmd(3'd0, 19'h12345, 0, 8'h00);
        check(rd_cnt == 1 && rbuf[0] == 8'hA5, "R2", "read back", rbuf[0], 8'hA5);
        check(viol == 0 && mreq_falls == 1, "R2", "read timing violations", viol, 0);
        check(oe_cycles == 0, "R8", "driver off during read", oe_cycles, 0);
        run_cmd(3'd0, 19'h00040, 7, 8'h00);
        check(rd_cnt == 1 && pulses_rd == 1 && rbuf[0] == 8'h03, "R2", "single read ignores length",
              rbuf[0], 8'h03);

        // Fill sweep.
        for (int n = 1; n <= 6; n++) begin
            logic [AW-1:0] a;
            int bad;
            a = 19'h20000 + 19'(n * 9);
            run_cmd(3'd2, a, n, 8'(8'h30 + n));
            bad = 0;
            for (int k = 0; k < n; k++) begin
                if (paddr[k] != a + 19'(k)) bad++;
                if (pdata[k] != 8'(8'h30 + n)) bad++;
                if (mem[6'(a + 19'(k))] != 8'(8'h30 + n)) bad++;
            end
            check(pulses_wr == n && mreq_falls == 1, "R5", "fill pulses", pulses_wr, n);
            check(bad == 0 && viol == 0, "R6", "fill data/address", bad + viol, 0);
        end

        // Stream read sweep.
        for (int n = 1; n <= 8; n++) begin
            logic [AW-1:0] a;
            int bad;
            a = 19'h01000 + 19'(n * 5);
            run_cmd(3'd3, a, n, 8'h00);
            bad = 0;
            for (int k = 0; k < n; k++) begin
                if (paddr[k] != a + 19'(k)) bad++;
                if (rbuf[k] != mem[6'(a + 19'(k))]) bad++;
            end
            check(rd_cnt == n && pulses_rd == n && mreq_falls == 1, "R5", "stream read count", rd_cnt, n);
            check(bad == 0 && viol == 0 && oe_cycles == 0, "R5", "stream read data/address", bad + viol, 0);
        end

        // Stream write with stalls.
        for (int n = 1; n <= 5; n++) begin
            logic [AW-1:0] a;
            int bad;
            a = 19'h33000 + 19'(n * 11);
            for (int k = 0; k < n; k++) wsrc[k] = 8'(8'hC0 ^ (n * 16 + k));
            run_cmd(3'd4, a, n, 8'h00);
            bad = 0;
            for (int k = 0; k < n; k++) begin
                if (paddr[k] != a + 19'(k)) bad++;
                if (mem[6'(a + 19'(k))] != wsrc[k]) bad++;
            end
            check(pulses_wr == n && mreq_falls == 1, "R7", "stream write pulses", pulses_wr, n);
            check(bad == 0 && viol == 0, "R7", "stream write data/order", bad + viol, 0);
        end

        // Address wrap at the top of the space.
        run_cmd(3'd3, 19'h7FFFE, 3, 8'h00);
        check(paddr[0] == 19'h7FFFE && paddr[1] == 19'h7FFFF && paddr[2] == 19'h00000,
              "R5", "address wrap", paddr[2], 0);
        check(viol == 0, "R11", "address held under strobe", viol, 0);

        // Zero length commands.
        for (int op = 2; op <= 4; op++) begin
            run_cmd(3'(op), 19'h00100, 0, 8'h77);
            check(mreq_falls == 0 && !busy_seen && pulse_n == 0, "R9", "zero length idle",
                  mreq_falls + int'(busy_seen), 0);
        end

        // Commands offered while busy are ignored.
        begin
            logic [7:0] m0;
            m0 = mem[0];
            clear_mon();
            cur_op = 3'd3;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 19'h00300; cmd_len = 8'd4;
            @(negedge clk);
            cmd_op = 3'd1; cmd_addr = 19'h00000; cmd_data = 8'hEE;
            check(!cmd_ready, "R10", "ready low while busy", cmd_ready, 0);
            while (busy) @(negedge clk);
            cmd_valid = 1'b0;
            @(negedge clk);
            check(pulses_rd == 4 && pulses_wr == 0 && mreq_falls == 1, "R10", "ignored while busy",
                  pulses_wr, 0);
            check(mem[0] == m0, "R10", "memory untouched", mem[0], m0);
        end

        // Unknown op codes.
        for (int op = 5; op <= 7; op++) begin
            run_cmd(3'(op), 19'h00010, 3, 8'h55);
            check(mreq_falls == 0 && !busy_seen && pulse_n == 0, "R12", "unknown op idle",
                  mreq_falls + int'(busy_seen), 0);
        end

        check(bus_mreq_n && bus_rd_n && bus_wr_n, "R4", "strobes high at end",
              {bus_mreq_n, bus_rd_n, bus_wr_n}, 3'b111);
        summary();
        $finish;
    end

endmodule